// File: doc/BRIEF.md
# Banked GPIO Port with Direction Register

An 8-bit general-purpose I/O port of the sort that sits beside a small processor core. It holds an output latch and a direction register. A synchronized copy of the pad inputs feeds the read path. Each pad sees an output enable and an output value, and returns the level it currently carries.

A host drives a single-command register bus. A command is a read, a full write, a bit-set or a bit-clear. The port data and direction registers share offset 0, and `bank_i` selects between them. A separate latch view at offset 1 can be included with a parameter.

Every command runs through a four-clock instruction cycle. The command is taken in phase 0 and its source is sampled in phase 1. The target is written in phase 3.

Bit operations on the port view take all eight pad levels as their source, not the latch. They then write the whole byte back. A high level on an input pin therefore ends up as a 1 in the latch. The latch view performs the same bit operations on the latch contents, so it does not have this problem. Open-drain signalling works by holding the latch at 0 and toggling only direction bits.

Top module: `gpio_bank_port`

## Requirements
- R1: After the asynchronous reset, every direction bit is 1, the output latch is 0, all output enables are low, and the phase counter is 0.
- R2: `pad_oe_o[i]` is the inverse of direction bit i. `pad_out_o` always carries the output latch.
- R3: A write or bit operation to the direction register (offset 0, bank 1) never changes the output latch.
- R4: A port read (offset 0, bank 0, op 00) returns the pad levels after a two-flop synchronizer. It leaves the output latch unchanged.
- R5: The latch and the direction register change only in phase 3, and only as the result of a write or bit command. A request presented outside phase 0 is ignored, and so is a request to an unmapped offset (2 or 3), which reads back 0.
- R6: Bit-set (op 10) and bit-clear (op 11) on the port view use the synchronized pad byte as source. They modify bit `bit_i` and write all bits to the latch, so an input pin seen high becomes 1 in the latch.
- R7: Bit operations at the latch view (offset 1) modify only the addressed bit of the latch contents. Reads there return the latch.
- R8: At offset 0, bank 1 addresses the direction register and bank 0 the port. A full write (op 01) stores `wdata_i` into the selected register.
- R9: `phase_o` counts 0,1,2,3 repeatedly. `rdata_o` updates at the phase-1 edge of a read, and the target register updates at the phase-3 edge.
- R10: In open-drain use (latch 0), a pin whose direction bit is 1 reads the external pull-up level, and a pin whose direction bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Command request, taken in phase 0 |
| op_i | input | 2 | 00 read, 01 write, 10 bit-set, 11 bit-clear |
| addr_i | input | 2 | Register offset: 0 port/direction, 1 latch view |
| bank_i | input | 1 | At offset 0: 1 direction, 0 port |
| bit_i | input | 3 | Bit index for set/clear |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| phase_o | output | 2 | Current instruction phase |
| pad_in_i | input | 8 | Levels present at the pads |
| pad_out_o | output | 8 | Output values to the pads |
| pad_oe_o | output | 8 | Per-pad output enable |

## Verification
The bench builds the block with its defaults: 8 pins, a two-bit offset, the latch view present and a two-stage synchronizer. With only eight pins, every bit index can be swept under both bit operations, on both the port view and the latch view, with varied direction and pull-up patterns. That sweep exposes the read-modify-write hazard pin by pin, and the bench's pad model computes the expected latch byte for each case. The small phase count lets the bench check the exact cycle at which read data and latch updates appear, and the rejection of requests presented outside phase 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    OP_RD   = 2'b00,
    OP_WR   = 2'b01,
    OP_BSET = 2'b10,
    OP_BCLR = 2'b11
  } gpio_op_e;

  typedef enum logic [1:0] {
    TGT_PORT = 2'd0,
    TGT_DIR  = 2'd1,
    TGT_LAT  = 2'd2,
    TGT_NONE = 2'd3
  } gpio_tgt_e;

  typedef struct packed {
    gpio_op_e  op;
    gpio_tgt_e tgt;
  } gpio_cmd_t;

  localparam logic [1:0] PH_CAPTURE = 2'd0;
  localparam logic [1:0] PH_SAMPLE  = 2'd1;
  localparam logic [1:0] PH_WRITE   = 2'd3;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_phase_gen.sv
module gpio_phase_gen
  import gpio_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] phase_o,
  output logic       cap_o,
  output logic       smp_o,
  output logic       wr_o
);
  logic [1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else ph_q <= ph_q + 2'd1;
  end

  assign phase_o = ph_q;
  assign cap_o   = (ph_q == PH_CAPTURE);
  assign smp_o   = (ph_q == PH_SAMPLE);
  assign wr_o    = (ph_q == PH_WRITE);
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter bit HAS_LAT = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  output gpio_tgt_e         tgt_o
);
  localparam logic [ADDR_W-1:0] OFS_PORT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_LAT  = ADDR_W'(1);

  always_comb begin
    tgt_o = TGT_NONE;
    if (addr_i == OFS_PORT) tgt_o = bank_i ? TGT_DIR : TGT_PORT;
    else if (HAS_LAT && addr_i == OFS_LAT) tgt_o = TGT_LAT;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 8,
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             smp_i,
  input  logic             wr_i,
  input  logic             req_i,
  input  gpio_cmd_t        cmd_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     pins_i,
  output logic [W-1:0]     lat_o,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     rdata_o
);
  logic             vld_q;
  gpio_cmd_t        cmd_q;
  logic [BIT_W-1:0] bit_q;
  logic [W-1:0]     wdata_q, src_q, lat_q, dir_q, rdata_q;
  logic [W-1:0]     src, mask, nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      cmd_q   <= '{op: OP_RD, tgt: TGT_NONE};
      bit_q   <= '0;
      wdata_q <= '0;
    end else if (cap_i) begin
      vld_q <= req_i;
      if (req_i) begin
        cmd_q   <= cmd_i;
        bit_q   <= bit_i;
        wdata_q <= wdata_i;
      end
    end
  end

  // source for reads and bit ops: port view sees pins, not latch
  always_comb begin
    unique case (cmd_q.tgt)
      TGT_PORT: src = pins_i;
      TGT_DIR:  src = dir_q;
      TGT_LAT:  src = lat_q;
      default:  src = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      rdata_q <= '0;
    end else if (smp_i && vld_q) begin
      src_q <= src;
      if (cmd_q.op == OP_RD) rdata_q <= src;
    end
  end

  assign mask = W'(1) << bit_q;

  always_comb begin
    unique case (cmd_q.op)
      OP_WR:   nxt = wdata_q;
      OP_BSET: nxt = src_q | mask;
      OP_BCLR: nxt = src_q & ~mask;
      default: nxt = src_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      dir_q <= '1;
    end else if (wr_i && vld_q && cmd_q.op != OP_RD) begin
      unique case (cmd_q.tgt)
        TGT_PORT, TGT_LAT: lat_q <= nxt;
        TGT_DIR:           dir_q <= nxt;
        default: ;
      endcase
    end
  end

  assign lat_o   = lat_q;
  assign dir_o   = dir_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
#(
  parameter int W           = 8,
  parameter int ADDR_W      = 2,
  parameter bit HAS_LAT     = 1'b1,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic [1:0]        phase_o,
  input  logic [W-1:0]      pad_in_i,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o
);
  logic         cap, smp, wr;
  logic [W-1:0] pins_s, lat, dir;
  gpio_tgt_e    tgt;
  gpio_cmd_t    cmd;

  gpio_phase_gen u_phase (
    .clk_i, .rst_ni, .phase_o, .cap_o(cap), .smp_o(smp), .wr_o(wr)
  );

  gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pins_s)
  );

  gpio_addr_dec #(.ADDR_W(ADDR_W), .HAS_LAT(HAS_LAT)) u_dec (
    .addr_i, .bank_i, .tgt_o(tgt)
  );

  assign cmd = '{op: gpio_op_e'(op_i), tgt: tgt};

  gpio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .cap_i(cap), .smp_i(smp), .wr_i(wr), .req_i,
    .cmd_i(cmd), .bit_i, .wdata_i, .pins_i(pins_s),
    .lat_o(lat), .dir_o(dir), .rdata_o
  );

  assign pad_out_o = lat;
  assign pad_oe_o  = ~dir;
endmodule

// File: rtl/gpio_bank_port_chk.sv
module gpio_bank_port_chk #(
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              bank_i,
  input logic [1:0]        phase_o,
  input logic [W-1:0]      pad_out_o,
  input logic [W-1:0]      pad_oe_o
);
  logic dir_cmd, port_rd;
  assign dir_cmd = req_i && phase_o == 2'd0 && addr_i == '0 && bank_i;
  assign port_rd = req_i && phase_o == 2'd0 && addr_i == '0 && !bank_i && op_i == 2'b00;

  assert_phase_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o == 2'($past(phase_o) + 2'd1));

  assert_latch_only_phase3_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3 |=> $stable(pad_out_o));

  assert_dir_only_phase3_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3 |=> $stable(pad_oe_o));

  assert_dir_cmd_keeps_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_cmd |-> ##4 $stable(pad_out_o));

  assert_port_read_keeps_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rd |-> ##4 ($stable(pad_out_o) && $stable(pad_oe_o)));
endmodule

bind gpio_bank_port gpio_bank_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
  .bank_i(bank_i), .phase_o(phase_o), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
);

// File: tb/sim_gpio_bank_port.sv
module sim_gpio_bank_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [1:0] addr_i = 2'd0;
  logic       bank_i = 1'b0;
  logic [2:0] bit_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o, pad_out_o, pad_oe_o, pad_in_i;
  logic [1:0] phase_o;
  logic [7:0] ext = 8'h00;   // pull-up / external level on released pins
  logic [7:0] m_lat, m_dir, exp_v;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  // pad model: driven pins carry the latch, released pins the external level
  assign pad_in_i = (pad_oe_o & pad_out_o) | (~pad_oe_o & ext);

  gpio_bank_port u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [1:0] ad, input logic bk,
                       input logic [2:0] b, input logic [7:0] d);
    while (phase_o != 2'd0) @(negedge clk_i);
    req_i = 1'b1; op_i = op; addr_i = ad; bank_i = bk; bit_i = b; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic idle();
    repeat (4) @(negedge clk_i);
  endtask

  function automatic logic [7:0] pins_of(logic [7:0] l, logic [7:0] dr, logic [7:0] e);
    return (~dr & l) | (dr & e);
  endfunction

  initial begin
    #200000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 oe", pad_oe_o, 8'h00);
    check("R1 latch", pad_out_o, 8'h00);
    check("R1 phase", {6'd0, phase_o}, 8'h00);
    rst_ni = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk_i);
      check("R9 phase seq", {6'd0, phase_o}, 8'(k % 4));
    end
    do_op(2'b00, 2'd0, 1'b1, 3'd0, 8'h00);
    check("R1 dir readback", rdata_o, 8'hFF);
    m_lat = 8'h00; m_dir = 8'hFF;

    // R8 / R2 / R3 / R4 pattern sweep
    for (int i = 0; i < 6; i++) begin
      logic [7:0] p, dv;
      p  = 8'h5A ^ 8'(i * 37);
      dv = 8'hC3 + 8'(i * 29);
      ext = 8'h96 ^ 8'(i * 11);
      do_op(2'b01, 2'd0, 1'b0, 3'd0, p); m_lat = p;
      check("R8 port write", pad_out_o, m_lat);
      do_op(2'b01, 2'd0, 1'b1, 3'd0, dv); m_dir = dv;
      check("R3 latch kept", pad_out_o, m_lat);
      check("R2 oe", pad_oe_o, ~m_dir);
      do_op(2'b00, 2'd0, 1'b1, 3'd0, 8'h00);
      check("R8 dir read", rdata_o, m_dir);
      idle();
      do_op(2'b00, 2'd0, 1'b0, 3'd0, 8'h00);
      check("R4 pin read", rdata_o, pins_of(m_lat, m_dir, ext));
      check("R4 latch kept", pad_out_o, m_lat);
    end

    // R6 hazard sweep and R7 latch-view sweep
    for (int v = 0; v < 2; v++) begin
      for (int b = 0; b < 8; b++) begin
        for (int o = 0; o < 2; o++) begin
          logic [7:0] src;
          ext = 8'(b * 53) ^ 8'hA5;
          m_dir = 8'hF0 ^ 8'(b * 17);
          m_lat = 8'(b * 71) ^ 8'h3C;
          do_op(2'b01, 2'd1, 1'b0, 3'd0, m_lat);
          do_op(2'b01, 2'd0, 1'b1, 3'd0, m_dir);
          idle();
          src = (v == 0) ? pins_of(m_lat, m_dir, ext) : m_lat;
          exp_v = (o == 0) ? (src | (8'h01 << b)) : (src & ~(8'h01 << b));
          do_op((o == 0) ? 2'b10 : 2'b11, (v == 0) ? 2'd0 : 2'd1, 1'b0, 3'(b), 8'h00);
          check((v == 0) ? "R6 port bitop" : "R7 latch bitop", pad_out_o, exp_v);
          m_lat = exp_v;
          if (v == 1) begin
            do_op(2'b00, 2'd1, 1'b0, 3'd0, 8'h00);
            check("R7 latch read", rdata_o, m_lat);
          end
        end
      end
    end

    // R10 open-drain
    ext = 8'hFF;
    do_op(2'b01, 2'd1, 1'b0, 3'd0, 8'h00); m_lat = 8'h00;
    for (int b = 0; b < 8; b++) begin
      do_op(2'b01, 2'd0, 1'b1, 3'd0, 8'hFF);
      do_op(2'b11, 2'd0, 1'b1, 3'(b), 8'h00);
      idle();
      do_op(2'b00, 2'd0, 1'b0, 3'd0, 8'h00);
      check("R10 od read", rdata_o, ~(8'h01 << b));
      check("R10 latch zero", pad_out_o, 8'h00);
    end

    // R9 timing of read data and latch update
    do_op(2'b01, 2'd0, 1'b1, 3'd0, 8'h00); m_dir = 8'h00;
    while (phase_o != 2'd0) @(negedge clk_i);
    req_i = 1'b1; op_i = 2'b00; addr_i = 2'd1; bank_i = 1'b0;
    @(negedge clk_i); req_i = 1'b0;
    @(negedge clk_i);
    check("R9 rdata after phase1", rdata_o, 8'h00);
    while (phase_o != 2'd0) @(negedge clk_i);
    req_i = 1'b1; op_i = 2'b01; addr_i = 2'd0; bank_i = 1'b0; wdata_i = 8'h7E;
    @(negedge clk_i); req_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R9 latch before phase3", pad_out_o, 8'h00);
    @(negedge clk_i);
    check("R9 latch at phase3", pad_out_o, 8'h7E);

    // R5 off-phase request and unmapped offset ignored
    while (phase_o != 2'd1) @(negedge clk_i);
    req_i = 1'b1; op_i = 2'b01; addr_i = 2'd0; bank_i = 1'b0; wdata_i = 8'h11;
    @(negedge clk_i); req_i = 1'b0;
    idle();
    check("R5 off-phase ignored", pad_out_o, 8'h7E);
    do_op(2'b01, 2'd2, 1'b0, 3'd0, 8'h22);
    check("R5 unmapped write", pad_out_o, 8'h7E);
    do_op(2'b00, 2'd3, 1'b0, 3'd0, 8'h00);
    check("R5 unmapped read", rdata_o, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule